// File: doc/BRIEF.md
# Real-Time Clock with Alarm and Periodic Interrupts

This block keeps the time of day as day, hour, minute and second counters, advanced once per second from a slow reference. The reference comes in as a single-cycle tick in the bus clock domain, and a fractional prescaler divides it into seconds. The control register selects one of three reference rates. A software-visible alarm is compared against the running time. When day, hour, minute and second all agree, an alarm status bit latches.

The prescaler also produces a family of periodic ticks, at 1 Hz and at every power of two from 2 Hz to 512 Hz. Each tick latches its own status bit. The status word is cleared by writing ones to it. An enable word gates which status bits drive the single interrupt line.

Software reaches every register over a plain 16-bit bus with a byte address, a write strobe and a write data word. The read data path is combinational. A write to any time register takes effect at once and restarts the sub-second phase, so the next second begins at the moment of the write.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset, every register reads zero: time, alarm, control, status and enable. The interrupt output is low and the clock is disabled.
- R2: Control bit 7 enables counting and reads back as written, and control bits 6:5 also read back. While bit 7 is 0, reference ticks do not advance the time.
- R3: Control bits 6:5 select the reference divisor. Code 00 selects RATE0_HZ (default 32768), code 01 selects RATE1_HZ (default 32000) and code 10 selects RATE2_HZ (default 38400). One second passes after exactly that many reference ticks; code 11 acts as 00.
- R4: The hour/minute register at offset 0x00 (alarm copy at 0x08) holds the hour in bits 15:8 and the minute in bits 7:0. The second registers are at 0x04 and 0x0C, and the day registers are at 0x20 and 0x24. A time write reads back on the next cycle and restarts the sub-second phase.
- R5: The seconds field wraps from 59 to 0 and carries into the minutes. The minutes wrap from 59 to 0 and carry into the hours, and the hours wrap from 23 to 0 and carry into the day.
- R6: The day counter is DAY_W bits wide (default 9) and wraps from its maximum value to 0.
- R7: Status bit 2 (offset 0x14) sets when day, hour, minute and second all first become equal to the alarm registers. A mismatch in any one field keeps it clear.
- R8: Status bit 4 latches a 1 Hz tick and bit 7 a 2 Hz tick. Bit 8+k latches a tick at 2^(k+2) Hz for k = 0..7, so bit 15 is 512 Hz.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A bit that is set stays set until it is cleared.
- R10: The interrupt is high exactly when some status bit and its enable bit (offset 0x18) are both set. Only enable bits 15:8, 7, 4 and 2 are writable, and status bit 0 never sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
Times are loaded just below each carry boundary: mid-minute, end of minute, end of hour, end of day and end of the day counter. This separates a wrong wrap value from a missing carry, field by field. Each reference rate code is timed against its neighbours' second length, which exposes a swapped divisor. The alarm is tried once with only the day differing, then with a full match, which tells a partial compare from a full one. The periodic bits are sampled at moments when only the fastest ticks can have occurred, which pins down their ordering.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [5:0] ADR_HRMIN  = 6'h00;
    localparam logic [5:0] ADR_SEC    = 6'h04;
    localparam logic [5:0] ADR_AHRMIN = 6'h08;
    localparam logic [5:0] ADR_ASEC   = 6'h0C;
    localparam logic [5:0] ADR_CTRL   = 6'h10;
    localparam logic [5:0] ADR_STAT   = 6'h14;
    localparam logic [5:0] ADR_IEN    = 6'h18;
    localparam logic [5:0] ADR_DAY    = 6'h20;
    localparam logic [5:0] ADR_ADAY   = 6'h24;

    localparam int BIT_ALARM = 2;
    localparam int BIT_HZ1   = 4;
    localparam int BIT_HZ2   = 7;
    localparam int BIT_SAMP0 = 8;
    localparam logic [15:0] STAT_IMPL = 16'hFF94;

    localparam int FRAC_W = 10;

    typedef struct packed {
        logic hrmin;
        logic sec;
        logic day;
        logic ahrmin;
        logic asec;
        logic aday;
    } wr_sel_t;
endpackage

// File: rtl/rtc_prescale.sv
module rtc_prescale
    import rtc_pkg::*;
#(
    parameter int RATE0_HZ = 32768,
    parameter int RATE1_HZ = 32000,
    parameter int RATE2_HZ = 38400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [1:0]        rate_sel,
    input  logic              ref_tick,
    output logic              sec_tick,
    output logic [FRAC_W-1:1] hz_tick
);
    localparam int STEP   = 1 << FRAC_W;
    localparam int MAX01  = (RATE0_HZ > RATE1_HZ) ? RATE0_HZ : RATE1_HZ;
    localparam int MAXDIV = (MAX01 > RATE2_HZ) ? MAX01 : RATE2_HZ;
    localparam int ACC_W  = $clog2(MAXDIV + STEP) + 1;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [FRAC_W-1:0] frac;
        logic              sec_p;
        logic [FRAC_W-1:1] hz_p;
    } pre_t;

    pre_t s_d, s_q;
    logic [ACC_W-1:0]  div;
    logic [ACC_W-1:0]  sum;
    logic [FRAC_W-1:0] nf;

    always_comb begin
        unique case (rate_sel)
            2'b01:   div = ACC_W'(RATE1_HZ);
            2'b10:   div = ACC_W'(RATE2_HZ);
            default: div = ACC_W'(RATE0_HZ);
        endcase
        sum = s_q.acc + ACC_W'(STEP);
        nf  = s_q.frac + 1'b1;
        s_d = s_q;
        s_d.sec_p = 1'b0;
        s_d.hz_p  = '0;
        if (restart) begin
            s_d.acc  = '0;
            s_d.frac = '0;
        end else if (run && ref_tick) begin
            if (sum >= div) begin
                s_d.acc   = sum - div;
                s_d.frac  = nf;
                s_d.sec_p = (nf == '0);
                for (int k = 1; k < FRAC_W; k++) begin
                    s_d.hz_p[k] = ((nf & ((FRAC_W'(1) << (FRAC_W - k)) - 1'b1)) == '0);
                end
            end else begin
                s_d.acc = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sec_tick = s_q.sec_p;
    assign hz_tick  = s_q.hz_p;
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep
    import rtc_pkg::*;
#(
    parameter int DAY_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  wr_sel_t          wr,
    input  logic [15:0]      wdata,
    output logic [5:0]       t_sec,
    output logic [5:0]       t_min,
    output logic [4:0]       t_hour,
    output logic [DAY_W-1:0] t_day,
    output logic [5:0]       a_sec,
    output logic [5:0]       a_min,
    output logic [4:0]       a_hour,
    output logic [DAY_W-1:0] a_day,
    output logic             alarm_hit
);
    typedef struct packed {
        logic [5:0]       sec;
        logic [5:0]       min;
        logic [4:0]       hour;
        logic [DAY_W-1:0] day;
        logic [5:0]       asec;
        logic [5:0]       amin;
        logic [4:0]       ahour;
        logic [DAY_W-1:0] aday;
        logic             match;
    } tk_t;

    tk_t s_d, s_q;
    logic same;

    always_comb begin
        same = (s_q.sec == s_q.asec) && (s_q.min == s_q.amin) &&
               (s_q.hour == s_q.ahour) && (s_q.day == s_q.aday);
        s_d = s_q;
        s_d.match = same;
        if (wr.hrmin || wr.sec || wr.day) begin
            if (wr.hrmin) begin
                s_d.hour = wdata[12:8];
                s_d.min  = wdata[5:0];
            end
            if (wr.sec) s_d.sec = wdata[5:0];
            if (wr.day) s_d.day = wdata[DAY_W-1:0];
        end else if (sec_tick) begin
            if (s_q.sec >= 6'd59) begin
                s_d.sec = '0;
                if (s_q.min >= 6'd59) begin
                    s_d.min = '0;
                    if (s_q.hour >= 5'd23) begin
                        s_d.hour = '0;
                        s_d.day  = s_q.day + 1'b1;
                    end else begin
                        s_d.hour = s_q.hour + 1'b1;
                    end
                end else begin
                    s_d.min = s_q.min + 1'b1;
                end
            end else begin
                s_d.sec = s_q.sec + 1'b1;
            end
        end
        if (wr.ahrmin) begin
            s_d.ahour = wdata[12:8];
            s_d.amin  = wdata[5:0];
        end
        if (wr.asec) s_d.asec = wdata[5:0];
        if (wr.aday) s_d.aday = wdata[DAY_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.match <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign t_sec     = s_q.sec;
    assign t_min     = s_q.min;
    assign t_hour    = s_q.hour;
    assign t_day     = s_q.day;
    assign a_sec     = s_q.asec;
    assign a_min     = s_q.amin;
    assign a_hour    = s_q.ahour;
    assign a_day     = s_q.aday;
    assign alarm_hit = same && !s_q.match;
endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
    import rtc_pkg::*;
#(
    parameter int DAY_W    = 9,
    parameter int RATE0_HZ = 32768,
    parameter int RATE1_HZ = 32000,
    parameter int RATE2_HZ = 38400
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic [5:0]  bus_addr,
    input  logic        bus_we,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq
);
    typedef struct packed {
        logic        run;
        logic [1:0]  rate;
        logic [15:0] stat;
        logic [15:0] ien;
    } top_t;

    top_t r_d, r_q;
    wr_sel_t wr;
    logic wr_time;
    logic sec_tick;
    logic [FRAC_W-1:1] hz_tick;
    logic [15:0] stat_set;
    logic [15:0] stat_clr;
    logic [5:0] cur_sec, cur_min, al_sec, al_min;
    logic [4:0] cur_hour, al_hour;
    logic [DAY_W-1:0] cur_day, al_day;
    logic alarm_hit;
    logic run;
    logic [15:0] stat_q;
    logic [15:0] ien_q;

    always_comb begin
        wr.hrmin  = bus_we && (bus_addr == ADR_HRMIN);
        wr.sec    = bus_we && (bus_addr == ADR_SEC);
        wr.day    = bus_we && (bus_addr == ADR_DAY);
        wr.ahrmin = bus_we && (bus_addr == ADR_AHRMIN);
        wr.asec   = bus_we && (bus_addr == ADR_ASEC);
        wr.aday   = bus_we && (bus_addr == ADR_ADAY);
    end
    assign wr_time = wr.hrmin || wr.sec || wr.day;

    rtc_prescale #(
        .RATE0_HZ(RATE0_HZ), .RATE1_HZ(RATE1_HZ), .RATE2_HZ(RATE2_HZ)
    ) u_pre (
        .clk(clk), .rst_n(rst_n), .run(r_q.run), .restart(wr_time),
        .rate_sel(r_q.rate), .ref_tick(ref_tick),
        .sec_tick(sec_tick), .hz_tick(hz_tick)
    );

    rtc_timekeep #(.DAY_W(DAY_W)) u_tk (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .wr(wr), .wdata(bus_wdata),
        .t_sec(cur_sec), .t_min(cur_min), .t_hour(cur_hour), .t_day(cur_day),
        .a_sec(al_sec), .a_min(al_min), .a_hour(al_hour), .a_day(al_day),
        .alarm_hit(alarm_hit)
    );

    always_comb begin
        stat_set = '0;
        stat_set[BIT_ALARM] = alarm_hit;
        stat_set[BIT_HZ1]   = sec_tick;
        stat_set[BIT_HZ2]   = hz_tick[1];
        for (int k = 0; k < 8; k++) begin
            stat_set[BIT_SAMP0 + k] = hz_tick[k + 2];
        end
        stat_clr = (bus_we && bus_addr == ADR_STAT) ? bus_wdata : '0;

        r_d = r_q;
        r_d.stat = ((r_q.stat & ~stat_clr) | stat_set) & STAT_IMPL;
        if (bus_we && bus_addr == ADR_CTRL) begin
            r_d.run  = bus_wdata[7];
            r_d.rate = bus_wdata[6:5];
        end
        if (bus_we && bus_addr == ADR_IEN) r_d.ien = bus_wdata & STAT_IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_HRMIN:  bus_rdata = {3'b0, cur_hour, 2'b0, cur_min};
            ADR_SEC:    bus_rdata = {10'b0, cur_sec};
            ADR_AHRMIN: bus_rdata = {3'b0, al_hour, 2'b0, al_min};
            ADR_ASEC:   bus_rdata = {10'b0, al_sec};
            ADR_CTRL:   bus_rdata = {8'b0, r_q.run, r_q.rate, 5'b0};
            ADR_STAT:   bus_rdata = r_q.stat;
            ADR_IEN:    bus_rdata = r_q.ien;
            ADR_DAY:    bus_rdata = 16'(cur_day);
            ADR_ADAY:   bus_rdata = 16'(al_day);
            default:    bus_rdata = '0;
        endcase
    end

    assign run    = r_q.run;
    assign stat_q = r_q.stat;
    assign ien_q  = r_q.ien;
    assign irq    = |(r_q.stat & r_q.ien);
endmodule

// File: rtl/rtc_alarm_core_chk.sv
module rtc_alarm_core_chk
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [5:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        irq,
    input logic [15:0] stat_q,
    input logic [15:0] ien_q,
    input logic [5:0]  cur_sec,
    input logic        sec_tick,
    input logic        run,
    input logic        wr_time,
    input logic        alarm_hit
);
    AST_ALARM_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> stat_q[BIT_ALARM]); // R7

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[BIT_ALARM] && !(bus_we && bus_addr == ADR_STAT && bus_wdata[BIT_ALARM]))
        |=> stat_q[BIT_ALARM]); // R9

    AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R10

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sec_tick && !wr_time) |=> $stable(cur_sec)); // R2

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_time && cur_sec < 6'd59) |=> (cur_sec == $past(cur_sec) + 6'd1)); // R5
endmodule

bind rtc_alarm_core rtc_alarm_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .irq(irq), .stat_q(stat_q), .ien_q(ien_q),
    .cur_sec(cur_sec), .sec_tick(sec_tick), .run(run), .wr_time(wr_time),
    .alarm_hit(alarm_hit)
);

// File: tb/tb_rtc_alarm_core.sv
`timescale 1ns/1ps
module tb_rtc_alarm_core;
    import rtc_pkg::*;

    localparam int SEC_CYC = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rtc_alarm_core #(
        .DAY_W(9), .RATE0_HZ(2048), .RATE1_HZ(2000), .RATE2_HZ(2400)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [8:0] d;
        logic [4:0] h;
        logic [5:0] m;
        logic [5:0] s;
    } tv_t;

    localparam int NV = 5;
    localparam tv_t STIM [NV] = '{
        {9'd0,   5'd0,  6'd0,  6'd5},
        {9'd3,   5'd4,  6'd7,  6'd59},
        {9'd10,  5'd5,  6'd59, 6'd59},
        {9'd100, 5'd23, 6'd59, 6'd59},
        {9'd511, 5'd23, 6'd59, 6'd59}
    };
    localparam tv_t EXPV [NV] = '{
        {9'd0,   5'd0,  6'd0,  6'd6},
        {9'd3,   5'd4,  6'd8,  6'd0},
        {9'd10,  5'd6,  6'd0,  6'd0},
        {9'd101, 5'd0,  6'd0,  6'd0},
        {9'd0,   5'd0,  6'd0,  6'd0}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state
        rd(ADR_HRMIN, v);  chk("R1 hrmin", v, 16'h0);
        rd(ADR_SEC, v);    chk("R1 sec", v, 16'h0);
        rd(ADR_DAY, v);    chk("R1 day", v, 16'h0);
        rd(ADR_AHRMIN, v); chk("R1 alarm hrmin", v, 16'h0);
        rd(ADR_ASEC, v);   chk("R1 alarm sec", v, 16'h0);
        rd(ADR_ADAY, v);   chk("R1 alarm day", v, 16'h0);
        rd(ADR_CTRL, v);   chk("R1 ctrl", v, 16'h0);
        rd(ADR_STAT, v);   chk("R1 stat", v, 16'h0);
        rd(ADR_IEN, v);    chk("R1 ien", v, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);

        // R2: disabled clock ignores reference ticks
        wr(ADR_SEC, 16'd5);
        wait_cyc(SEC_CYC + 100);
        rd(ADR_SEC, v); chk("R2 no count while disabled", v, 16'd5);

        wr(ADR_CTRL, 16'h0080);
        rd(ADR_CTRL, v); chk("R2 enable readback", v, 16'h0080);

        // R5 R6: table of carry boundaries
        for (int i = 0; i < NV; i++) begin
            wr(ADR_DAY, 16'(STIM[i].d));
            wr(ADR_HRMIN, {3'b0, STIM[i].h, 2'b0, STIM[i].m});
            wr(ADR_SEC, {10'b0, STIM[i].s});
            wait_cyc(SEC_CYC - 8);
            rd(ADR_SEC, v); chk("R5 sec before tick", v, {10'b0, STIM[i].s});
            wait_cyc(20);
            rd(ADR_SEC, v);   chk("R5 sec after tick", v, {10'b0, EXPV[i].s});
            rd(ADR_HRMIN, v); chk("R5 hour/min after tick", v, {3'b0, EXPV[i].h, 2'b0, EXPV[i].m});
            rd(ADR_DAY, v);   chk(i == NV - 1 ? "R6 day wrap" : "R5 day after tick", v, 16'(EXPV[i].d));
        end
        // R7: the last vector reached 0 0:00:00, equal to the all-zero alarm
        rd(ADR_STAT, v); chk("R7 alarm at zero time", v & 16'h0004, 16'h0004);

        // R4: immediate readback and prescaler restart
        wr(ADR_HRMIN, 16'h0A1E);
        rd(ADR_HRMIN, v); chk("R4 hrmin readback", v, 16'h0A1E);
        wr(ADR_SEC, 16'd10);
        wait_cyc(1500);
        wr(ADR_SEC, 16'd20);
        rd(ADR_SEC, v); chk("R4 sec readback", v, 16'd20);
        wait_cyc(1000);
        rd(ADR_SEC, v); chk("R4 restart delays tick", v, 16'd20);
        wait_cyc(1100);
        rd(ADR_SEC, v); chk("R4 tick after restart", v, 16'd21);

        // R3: rate selection
        wr(ADR_CTRL, 16'h00A0);
        rd(ADR_CTRL, v); chk("R2 rate field readback", v, 16'h00A0);
        wr(ADR_SEC, 16'd0);
        wait_cyc(2010);
        rd(ADR_SEC, v); chk("R3 code 01 second", v, 16'd1);
        wr(ADR_CTRL, 16'h00C0);
        wr(ADR_SEC, 16'd0);
        wait_cyc(2100);
        rd(ADR_SEC, v); chk("R3 code 10 not yet", v, 16'd0);
        wait_cyc(320);
        rd(ADR_SEC, v); chk("R3 code 10 second", v, 16'd1);
        wr(ADR_CTRL, 16'h0080);

        // R8: periodic ticks in order of rate
        wr(ADR_STAT, 16'hFFFF);
        wr(ADR_SEC, 16'd0);
        wait_cyc(10);
        rd(ADR_STAT, v); chk("R8 512/256 Hz first", v, 16'hC000);
        wait_cyc(1020);
        rd(ADR_STAT, v); chk("R8 down to 2 Hz", v, 16'hFF80);
        wait_cyc(1030);
        rd(ADR_STAT, v); chk("R8 1 Hz set", v, 16'hFF90);
        chk("R10 no irq without enable", {15'b0, irq}, 16'h0);

        // R9: write-one-to-clear
        wr(ADR_STAT, 16'h0010);
        rd(ADR_STAT, v); chk("R9 clear bit 4 only", v, 16'hFF80);
        wr(ADR_STAT, 16'h0000);
        rd(ADR_STAT, v); chk("R9 zero write keeps", v, 16'hFF80);

        // R10: enable mask and irq
        wr(ADR_IEN, 16'hFFFF);
        rd(ADR_IEN, v); chk("R10 enable mask", v, 16'hFF94);
        chk("R10 irq with enable", {15'b0, irq}, 16'h1);
        wr(ADR_IEN, 16'h0000);
        wr(ADR_CTRL, 16'h0000);
        wr(ADR_STAT, 16'hFFFF);
        rd(ADR_STAT, v); chk("R9 clear all", v, 16'h0);

        // R7: alarm needs every field to match
        wr(ADR_IEN, 16'h0004);
        wr(ADR_ADAY, 16'd1);
        wr(ADR_AHRMIN, 16'h0000);
        wr(ADR_ASEC, 16'd59);
        wr(ADR_DAY, 16'd0);
        wr(ADR_HRMIN, 16'h0000);
        wr(ADR_SEC, 16'd58);
        wr(ADR_CTRL, 16'h0080);
        wait_cyc(SEC_CYC + 20);
        rd(ADR_SEC, v); chk("R5 reached 59", v, 16'd59);
        wr(ADR_CTRL, 16'h0000);
        rd(ADR_STAT, v); chk("R7 day mismatch no alarm", v & 16'h0004, 16'h0);
        chk("R10 irq low", {15'b0, irq}, 16'h0);
        wr(ADR_ADAY, 16'd0);
        wait_cyc(2);
        rd(ADR_STAT, v); chk("R7 full match", v & 16'h0004, 16'h0004);
        chk("R10 irq on alarm", {15'b0, irq}, 16'h1);
        wr(ADR_STAT, 16'h0004);
        wait_cyc(2);
        rd(ADR_STAT, v); chk("R9 alarm cleared", v & 16'h0004, 16'h0);
        chk("R10 irq released", {15'b0, irq}, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule